// File: doc/BRIEF.md
# Edge-Sensing GPIO Port Controller

This block is an eight-pin general-purpose I/O port for a register-mapped peripheral bus. Each pin has its own direction bit. When the direction bit is set, the stored data bit drives the pin and the output enable is raised. When it is clear, the pin is an input. Pin inputs pass through a two-flop synchronizer before any logic uses them.

A fixed subset of the pins (0, 1, 6 and 7 by default) can raise interrupts. Software picks a rising or falling edge per pin with a polarity bit. A detected edge sets a sticky flag that software clears by writing a one to it. Flags whose enable bit is set are ORed into a single registered interrupt request.

Software accesses the block through a small bus that has an address, a write strobe, write data, and combinational read data.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register (data, direction, polarity, enable, flags) reads 0, `pin_oe` is 0 and `irq` is 0.
- R2: A write to the direction register (address 1) sets `pin_oe` to the written value after the next clock edge. A write to the data register (address 0) sets `pin_out` to the written value after the next clock edge.
- R3: A read of address 0 returns the stored data bit for each pin whose direction bit is 1, and the synchronized pin state for each pin whose direction bit is 0.
- R4: A change on `pin_in` shows in an address-0 read of an input pin after exactly two rising clock edges, and not after one.
- R5: With polarity bit 0, a falling edge on an interrupt-capable pin sets its flag (address 4), and a rising edge does not.
- R6: With polarity bit 1, a rising edge sets the flag, and a falling edge does not.
- R7: Writing 1 to a flag bit at address 4 clears it. Writing 0 leaves it unchanged.
- R8: If an active edge and a write-one-to-clear hit the same flag bit in the same cycle, the flag ends up set.
- R9: Flag bits 5 to 2 always read 0. Edges on pins 2 to 5 and writes to those flag bits have no effect on them.
- R10: `irq` is 1 one cycle after any flag bit is set together with its enable bit (address 3), and 0 otherwise.
- R11: The map is: 0 data, 1 direction, 2 polarity, 3 enable, 4 flags. Addresses 1 to 3 read back what was written. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 8 | Asynchronous pin input levels |
| pin_out | output | 8 | Output levels to the pads |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is the collision between a new active edge and a clear of the same flag in one cycle. The edge only reaches the detector two clock edges after the pin moves, so the clear write has to be placed in exactly that window. The bench first sets the flag and returns the pin to its idle level. It then moves the pin on a falling clock edge, waits two more falling edges, and issues the clear. The clear then lands on the same rising edge as the detected edge, and a read afterwards must still show the flag set.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int PORT_W     = 8;
    localparam int REG_ADDR_W = 3;
    localparam int SYNC_DEPTH = 2;

    // Pins that carry interrupt logic: 7, 6, 1, 0
    localparam logic [PORT_W-1:0] IRQ_PIN_MASK = 8'b1100_0011;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_DIR  = 3'd1,
        REG_POL  = 3'd2,
        REG_IEN  = 3'd3,
        REG_FLAG = 3'd4
    } reg_sel_e;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic                  we;
        logic [REG_ADDR_W-1:0] addr;
    } bus_req_t;

    // True when the transition prev->cur matches the selected polarity
    function automatic logic edge_match(input logic prev, input logic cur,
                                        input edge_pol_e pol);
        if (pol == EDGE_RISE)
            return ~prev & cur;
        else
            return prev & ~cur;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = gpio_edge_pkg::PORT_W,
    parameter int STAGES = gpio_edge_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_edge_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int ADDR_W = REG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      pol_q,
    output logic [W-1:0]      ien_q
);

    bus_req_t req;
    assign req.we   = bus_we;
    assign req.addr = bus_addr;

    logic wr_data, wr_dir, wr_pol, wr_ien;

    always_comb begin
        wr_data = req.we && (req.addr == REG_DATA);
        wr_dir  = req.we && (req.addr == REG_DIR);
        wr_pol  = req.we && (req.addr == REG_POL);
        wr_ien  = req.we && (req.addr == REG_IEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
            pol_q  <= '0;
            ien_q  <= '0;
        end else begin
            if (wr_data) data_q <= bus_wdata;
            if (wr_dir)  dir_q  <= bus_wdata;
            if (wr_pol)  pol_q  <= bus_wdata;
            if (wr_ien)  ien_q  <= bus_wdata;
        end
    end

endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags
    import gpio_edge_pkg::*;
#(
    parameter int          W    = PORT_W,
    parameter int          ADDR_W = REG_ADDR_W,
    parameter logic [W-1:0] MASK = IRQ_PIN_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      sync_in,
    input  logic [W-1:0]      pol,
    input  logic [W-1:0]      ien,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      edge_hit,
    output logic [W-1:0]      flag_q,
    output logic              irq_q
);

    logic [W-1:0] prev_q;
    logic [W-1:0] clr_req;
    logic [W-1:0] flag_d;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sync_in;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            if (MASK[i]) begin : g_irq
                assign edge_hit[i] = edge_match(prev_q[i], sync_in[i],
                                                edge_pol_e'(pol[i]));
            end else begin : g_plain
                // No interrupt logic: keep the level history unused except here
                assign edge_hit[i] = 1'b0 & (prev_q[i] ^ sync_in[i] ^ pol[i]);
            end
        end
    endgenerate

    always_comb begin
        clr_req = '0;
        if (bus_we && (bus_addr == REG_FLAG))
            clr_req = bus_wdata & MASK;
        // A new edge overrides a simultaneous clear
        flag_d = ((flag_q & ~clr_req) | edge_hit) & MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            irq_q  <= |(flag_q & ien & MASK);
        end
    end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int           W        = PORT_W,
    parameter int           ADDR_W   = REG_ADDR_W,
    parameter int           STAGES   = SYNC_DEPTH,
    parameter logic [W-1:0] IRQ_MASK = IRQ_PIN_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              irq
);

    logic [W-1:0] pin_sync;
    logic [W-1:0] data_q, dir_q, pol_q, ien_q;
    logic [W-1:0] flag_q, edge_hit;

    gpio_sync #(.W(W), .STAGES(STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_ctrl_regs #(.W(W), .ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .pol_q     (pol_q),
        .ien_q     (ien_q)
    );

    gpio_irq_flags #(.W(W), .ADDR_W(ADDR_W), .MASK(IRQ_MASK)) flags_i (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (pin_sync),
        .pol       (pol_q),
        .ien       (ien_q),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .edge_hit  (edge_hit),
        .flag_q    (flag_q),
        .irq_q     (irq)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;

    always_comb begin
        case (bus_addr)
            REG_DATA: bus_rdata = (data_q & dir_q) | (pin_sync & ~dir_q);
            REG_DIR:  bus_rdata = dir_q;
            REG_POL:  bus_rdata = pol_q;
            REG_IEN:  bus_rdata = ien_q;
            REG_FLAG: bus_rdata = flag_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
    import gpio_edge_pkg::*;
#(
    parameter int           W      = PORT_W,
    parameter int           ADDR_W = REG_ADDR_W,
    parameter logic [W-1:0] MASK   = IRQ_PIN_MASK
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic              irq,
    input logic [W-1:0]      ien_q,
    input logic [W-1:0]      flag_q,
    input logic [W-1:0]      edge_hit
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        (!rst && !armed) |-> (flag_q == '0 && !irq && pin_oe == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && bus_we && bus_addr == REG_DIR) |=> (pin_oe == $past(bus_wdata)));

    // R2
    data_write_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && bus_we && bus_addr == REG_DATA) |=> (pin_out == $past(bus_wdata)));

    // R5
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && (|edge_hit)) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && bus_we && bus_addr == REG_FLAG)
            |=> ((flag_q & $past(bus_wdata & ~edge_hit)) == '0));

    // R9
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_FLAG) |-> ((bus_rdata & ~MASK) == '0));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        armed |=> (irq == $past(|(flag_q & ien_q))));

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.W(W), .ADDR_W(ADDR_W), .MASK(IRQ_MASK)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .ien_q     (ien_q),
    .flag_q    (flag_q),
    .edge_hit  (edge_hit)
);

// File: tb/gpio_edge_port_tb_top.sv
module gpio_edge_port_tb_top;

    localparam int  W        = 8;
    localparam int  HALF     = 5;   // 200 MHz: 5 ns period, ticks of 0.5 ns
    localparam logic [2:0] A_DATA = 3'd0, A_DIR = 3'd1, A_POL = 3'd2,
                           A_IEN = 3'd3, A_FLAG = 3'd4;

    timeunit 1ns; timeprecision 100ps;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out, pin_oe;
    logic         irq;

    always #2.5 clk = ~clk;

    gpio_edge_port dut_i (
        .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_we (bus_we),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pin_in (pin_in),
        .pin_out (pin_out), .pin_oe (pin_oe), .irq (irq)
    );

    typedef struct {
        logic [2:0]   addr;
        logic [W-1:0] exp;
        string        tag;
    } rd_item_t;

    rd_item_t exp_q[$];
    logic     rd_req = 1'b0;
    int       n_chk = 0;
    int       n_bad = 0;
    bit       finished = 1'b0;

    // Monitor: pops an expected read and compares it mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_req && exp_q.size() > 0) begin
                rd_item_t it;
                it = exp_q.pop_front();
                n_chk++;
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: read addr %0d got %02h expected %02h",
                             it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    // Driver tasks: all called at a falling edge
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [W-1:0] e,
                             input string tag);
        rd_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        bus_addr = a;
        exp_q.push_back(it);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk_sig(input logic [W-1:0] act, input logic [W-1:0] e,
                           input string tag);
        #1;
        n_chk++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, e);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset values
        chk_sig(pin_oe, 8'h00, "R1 pin_oe");
        chk_sig({7'b0, irq}, 8'h00, "R1 irq");
        @(negedge clk);
        rd_expect(A_DATA, 8'h00, "R1 data");
        rd_expect(A_DIR,  8'h00, "R1 dir");
        rd_expect(A_POL,  8'h00, "R1 pol");
        rd_expect(A_IEN,  8'h00, "R1 ien");
        rd_expect(A_FLAG, 8'h00, "R1 flag");
        // R11 unmapped addresses
        rd_expect(3'd5, 8'h00, "R11 addr5");
        rd_expect(3'd7, 8'h00, "R11 addr7");

        // R2 direction and output drive
        wr(A_DIR, 8'hF0);
        wr(A_DATA, 8'hA5);
        chk_sig(pin_oe, 8'hF0, "R2 pin_oe");
        chk_sig(pin_out, 8'hA5, "R2 pin_out");
        @(negedge clk);
        rd_expect(A_DIR, 8'hF0, "R11 dir readback");

        // R3 mixed read: outputs from register, inputs from pins
        pin_in = 8'h3C;
        idle(3);
        rd_expect(A_DATA, 8'hAC, "R3 mixed read");
        rd_expect(A_FLAG, 8'h00, "R9 rising on 5..2 no flag");

        // R4 synchronizer latency, all inputs
        wr(A_DIR, 8'h00);
        pin_in = 8'h3D;
        rd_expect(A_DATA, 8'h3C, "R4 before any edge");
        rd_expect(A_DATA, 8'h3C, "R4 after one edge");
        rd_expect(A_DATA, 8'h3D, "R4 after two edges");
        rd_expect(A_FLAG, 8'h00, "R5 rising ignored with pol 0");

        // R5 falling edge on pin 0
        pin_in = 8'h3C;
        idle(4);
        rd_expect(A_FLAG, 8'h01, "R5 falling sets flag0");
        chk_sig({7'b0, irq}, 8'h00, "R10 no irq while disabled");

        // R10 enable gating
        wr(A_IEN, 8'h01);
        idle(2);
        chk_sig({7'b0, irq}, 8'h01, "R10 irq with enable");
        @(negedge clk);
        wr(A_IEN, 8'h00);
        idle(2);
        chk_sig({7'b0, irq}, 8'h00, "R10 irq drops when disabled");
        @(negedge clk);
        wr(A_IEN, 8'h01);
        rd_expect(A_IEN, 8'h01, "R11 ien readback");

        // R7 write-one-to-clear
        wr(A_FLAG, 8'hFE);
        rd_expect(A_FLAG, 8'h01, "R7 write zero keeps flag");
        wr(A_FLAG, 8'h01);
        rd_expect(A_FLAG, 8'h00, "R7 write one clears flag");
        idle(2);
        chk_sig({7'b0, irq}, 8'h00, "R10 irq low after clear");
        @(negedge clk);

        // R6 rising polarity on pin 7
        wr(A_POL, 8'h80);
        rd_expect(A_POL, 8'h80, "R11 pol readback");
        pin_in = 8'hBC;
        idle(4);
        rd_expect(A_FLAG, 8'h80, "R6 rising sets flag7");
        wr(A_FLAG, 8'h80);
        pin_in = 8'h3C;
        idle(4);
        rd_expect(A_FLAG, 8'h00, "R6 falling ignored with pol 1");

        // R9 falling edges on pins 5..2 with pol 0, and writes there
        wr(A_POL, 8'h00);
        pin_in = 8'h00;
        idle(4);
        rd_expect(A_FLAG, 8'h00, "R9 falling on 5..2 no flag");
        wr(A_FLAG, 8'h3C);
        rd_expect(A_FLAG, 8'h00, "R9 write to 5..2 ignored");

        // R8 edge and clear in the same cycle on pin 1 (falling active)
        pin_in = 8'h02;
        idle(4);
        rd_expect(A_FLAG, 8'h00, "R8 setup rising ignored");
        pin_in = 8'h00;
        idle(4);
        rd_expect(A_FLAG, 8'h02, "R8 setup flag1 set");
        pin_in = 8'h02;
        idle(4);
        pin_in = 8'h00;
        idle(2);
        wr(A_FLAG, 8'h02);
        rd_expect(A_FLAG, 8'h02, "R8 set wins over clear");
        wr(A_FLAG, 8'h02);
        rd_expect(A_FLAG, 8'h00, "R7 later clear works");

        idle(2);
        finished = 1'b1;
        finish_run();
    end

    // Watchdog
    initial begin
        #(200000 * HALF / 1.0);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule